// File: doc/BRIEF.md
# Cache Block Operation Sequencer

This block carries out cache-block management requests from a processor pipeline. A request carries an operation code (flush, invalidate or zero), the raw register address and the result of address translation for that address. The sequencer takes the cache block that holds the address as its target and sends the matching command to a cache/memory port. It waits for that port's response and then sends one completion pulse back to the pipeline. That pulse is either a done or a fault with a cause code and a trap value.

Flush and invalidate each go out as a single command at block level. A zero operation is split into one full-width write of zeros per data-path word of the block. A 2-bit configuration field decides whether invalidate runs as a real invalidate, runs as a flush, or is refused as an illegal instruction. The block handles one request at a time. Translation, the caches and decode sit outside it.

Top module: `cbo_seq`

## Requirements
- R1: Every command issued on the memory port addresses the block that contains the request address. Flush and invalidate use the block base, which is the request address with its low log2(BLK_BYTES) bits cleared. Command code 00 means flush, 01 means invalidate and 10 means write.
- R2: An address that is not aligned to the block is accepted like an aligned one and completes with done. No alignment fault exists.
- R3: A zero request (op 10) issues BLK_BYTES/(DATA_W/8) write commands at block base + k·(DATA_W/8), in ascending k. Each write carries all-zero data and all byte strobes set. Done follows the last response.
- R4: For op 01 (invalidate), cfg_inval 11 issues command 01 and cfg_inval 01 issues command 00. With cfg_inval 00 or 10 the request faults with cause 00 (illegal instruction) and issues no command. Op 11 also faults with cause 00. This illegal-instruction check takes precedence over a translation fault.
- R5: A non-zero translation result (01 page fault, 10 guest-page fault, 11 access fault) makes the request fault with a cause equal to that code. Nothing is issued on the memory port. In every fault, fault_tval equals the unmodified request address.
- R6: An error response on any memory beat ends the request at once with cause 11 (access fault) and the raw address as trap value. No further beats of that request are issued.
- R7: req_ready is low from the accepting cycle until the request completes. Each accepted request produces exactly one done_o or fault_o pulse, never both at once.
- R8: While mem_valid is high and mem_ready is low, mem_valid stays high and mem_cmd and mem_addr stay stable.
- R9: After reset, req_ready is high, and mem_valid, done_o and fault_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_op | input | 2 | 00 flush, 01 invalidate, 10 zero, 11 illegal |
| req_addr | input | ADDR_W | Raw register address |
| req_xlat_fault | input | 2 | Translation result: 00 ok, 01 page, 10 guest-page, 11 access |
| cfg_inval | input | 2 | Invalidate policy field |
| mem_valid | output | 1 | Command valid |
| mem_ready | input | 1 | Command accepted |
| mem_cmd | output | 2 | 00 flush, 01 invalidate, 10 write |
| mem_addr | output | ADDR_W | Command address |
| mem_wdata | output | DATA_W | Write data (zeros) |
| mem_wstrb | output | DATA_W/8 | Byte strobes |
| mem_rsp_valid | input | 1 | Response for the last accepted command |
| mem_rsp_err | input | 1 | Response reports an access error |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_cause | output | 2 | 00 illegal, 01 page, 10 guest-page, 11 access |
| fault_tval | output | ADDR_W | Trap value, the raw request address |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 64-byte blocks and a 64-bit data path. This gives a six-bit block offset and eight write beats per zero request. Under these values, addresses with every offset bit set, and the top block of the address space, can be exercised directly. An injected error can be placed in the middle of the beat train, with 4 of 8 beats seen before it aborts. A memory stub that stalls every other command keeps the hold rule in play on each zero beat.

// File: rtl/cbo_seq.sv
module cbo_seq #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64,
  parameter int DATA_W    = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_op,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [1:0]            req_xlat_fault,
  input  logic [1:0]            cfg_inval,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic [1:0]            mem_cmd,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [DATA_W/8-1:0]   mem_wstrb,
  input  logic                  mem_rsp_valid,
  input  logic                  mem_rsp_err,
  output logic                  done_o,
  output logic                  fault_o,
  output logic [1:0]            fault_cause,
  output logic [ADDR_W-1:0]     fault_tval
);
  localparam int OFF_W  = $clog2(BLK_BYTES);
  localparam int STRB_W = DATA_W / 8;
  localparam int LANE_W = $clog2(STRB_W);
  localparam int BEATS  = BLK_BYTES / STRB_W;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;

  st_t               st;
  logic [1:0]        cmd_q;
  logic [1:0]        cause_q;
  logic [ADDR_W-1:0] raw_q;
  logic [BEAT_W-1:0] beat_q;

  wire accept  = req_valid && req_ready;
  wire illegal = (req_op == 2'b11) || (req_op == 2'b01 && !cfg_inval[0]);
  wire [1:0] new_cmd = (req_op == 2'b01) ? {1'b0, cfg_inval[1]} : req_op;
  wire last_beat = (cmd_q != 2'b10) || (beat_q == BEAT_W'(BEATS - 1));

  assign req_ready   = (st == S_IDLE);
  assign mem_valid   = (st == S_ISSUE);
  assign mem_cmd     = cmd_q;
  assign mem_addr    = {raw_q[ADDR_W-1:OFF_W], OFF_W'(0)} | (ADDR_W'(beat_q) << LANE_W);
  assign mem_wdata   = '0;
  assign mem_wstrb   = '1;
  assign fault_cause = cause_q;
  assign fault_tval  = raw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cmd_q   <= 2'b00;
      cause_q <= 2'b00;
      raw_q   <= '0;
      beat_q  <= '0;
      done_o  <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          raw_q  <= req_addr;
          beat_q <= '0;
          cmd_q  <= new_cmd;
          if (illegal) begin
            fault_o <= 1'b1;
            cause_q <= 2'b00;
          end else if (req_xlat_fault != 2'b00) begin
            fault_o <= 1'b1;
            cause_q <= req_xlat_fault;
          end else begin
            st <= S_ISSUE;
          end
        end
        S_ISSUE: if (mem_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            fault_o <= 1'b1;
            cause_q <= 2'b11;
            st      <= S_IDLE;
          end else if (!last_beat) begin
            beat_q <= beat_q + 1'b1;
            st     <= S_ISSUE;
          end else begin
            done_o <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cbo_seq_chk.sv
module cbo_seq_chk #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64,
  parameter int DATA_W    = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                mem_valid,
  input logic                mem_ready,
  input logic [1:0]          mem_cmd,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W/8-1:0] mem_wstrb,
  input logic                done_o,
  input logic                fault_o,
  input logic [1:0]          fault_cause,
  input logic [ADDR_W-1:0]   fault_tval
);
  localparam int OFF_W  = $clog2(BLK_BYTES);
  localparam int LANE_W = $clog2(DATA_W / 8);
  localparam int BEATS  = BLK_BYTES / (DATA_W / 8);

  logic [ADDR_W-1:0] c_raw;
  int unsigned       c_hs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_raw <= '0;
      c_hs  <= 0;
    end else if (req_valid && req_ready) begin
      c_raw <= req_addr;
      c_hs  <= 0;
    end else if (mem_valid && mem_ready) begin
      c_hs <= c_hs + 1;
    end
  end

  a_r1_same_block: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[ADDR_W-1:OFF_W] == c_raw[ADDR_W-1:OFF_W]);
  a_r1_block_base: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_cmd != 2'b10) |-> mem_addr[OFF_W-1:0] == '0);
  a_r3_lane_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[LANE_W-1:0] == '0 && &mem_wstrb));
  a_r3_beat_limit: assert property (@(posedge clk) disable iff (!rst_n)
    c_hs <= BEATS);
  a_r4_illegal_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && fault_cause == 2'b00) |-> c_hs == 0);
  a_r5_raw_tval: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> fault_tval == c_raw);
  a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fault_o));
  a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_cmd)));
endmodule

bind cbo_seq cbo_seq_chk #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_cmd(mem_cmd), .mem_addr(mem_addr), .mem_wstrb(mem_wstrb),
  .done_o(done_o), .fault_o(fault_o), .fault_cause(fault_cause),
  .fault_tval(fault_tval));

// File: tb/cbo_seq_test.sv
`timescale 1ns/1ps
module cbo_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_xlat_fault = 2'b00;
  logic [1:0]  cfg_inval = 2'b11;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [1:0]  mem_cmd;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_wstrb;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_err = 1'b0;
  logic        done_o, fault_o;
  logic [1:0]  fault_cause;
  logic [31:0] fault_tval;

  cbo_seq uut (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cpl_cnt = 0;
  logic [33:0] exp_mem[$];
  logic [34:0] exp_cpl[$];
  string cur_tag = "";
  int inj_at = -1, hs_idx = 0;
  bit stall = 0, stall_tog = 0, rsp_due = 0, rsp_err_next = 0, held = 0;
  logic [33:0] held_val;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, cur_tag, act, expv);
    end
  endtask

  initial begin : mem_and_monitor
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      if (rsp_due) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_err   = rsp_err_next;
        rsp_due = 0;
      end
      if (held) begin
        chk(mem_valid && {mem_cmd, mem_addr} == held_val, "R8", {mem_valid, mem_cmd, mem_addr}, {1'b1, held_val});
        held = 0;
      end
      if (mem_valid) begin
        if (stall && !stall_tog) begin
          mem_ready = 1'b0;
          stall_tog = 1;
          held = 1;
          held_val = {mem_cmd, mem_addr};
        end else begin
          mem_ready = 1'b1;
          stall_tog = 0;
          if (exp_mem.size() == 0) begin
            chk(0, "R6 no extra command", {mem_cmd, mem_addr}, 0);
          end else begin
            logic [33:0] e;
            e = exp_mem.pop_front();
            chk({mem_cmd, mem_addr} == e, (e[33:32] == 2'b10) ? "R3" : "R1/R4", {mem_cmd, mem_addr}, e);
            if (e[33:32] == 2'b10)
              chk(mem_wdata == '0 && mem_wstrb == 8'hFF, "R3 data", {mem_wstrb, mem_wdata[55:0]}, 64'hFF00000000000000);
          end
          rsp_err_next = (hs_idx == inj_at);
          hs_idx++;
          rsp_due = 1;
        end
      end else begin
        mem_ready = 1'b0;
      end
      if (done_o || fault_o) begin
        chk(!(done_o && fault_o), "R7 both", {done_o, fault_o}, 0);
        if (exp_cpl.size() == 0) begin
          chk(0, "R7 extra completion", {fault_o, fault_cause, fault_tval}, 0);
        end else begin
          logic [34:0] c;
          c = exp_cpl.pop_front();
          if (c[34])
            chk(fault_o && {fault_cause, fault_tval} == c[33:0], "R4/R5/R6 fault", {fault_o, fault_cause, fault_tval}, c);
          else
            chk(done_o, "R2/R3 done", {fault_o, fault_cause, fault_tval}, c);
        end
        cpl_cnt++;
      end
    end
  end

  task automatic do_req(input logic [1:0] op, input logic [31:0] addr, input logic [1:0] xf,
                        input logic [1:0] cfg, input int err_at, input bit stl, input string tag);
    logic [31:0] base;
    bit ill;
    int n, nb;
    cur_tag = tag;
    base = addr & ~32'h3F;
    ill  = (op == 2'b11) || (op == 2'b01 && (cfg == 2'b00 || cfg == 2'b10));
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_xlat_fault = xf; cfg_inval = cfg;
    inj_at = err_at; hs_idx = 0; stall = stl; stall_tog = 0;
    n = cpl_cnt;
    if (ill)                exp_cpl.push_back({1'b1, 2'b00, addr});
    else if (xf != 2'b00)   exp_cpl.push_back({1'b1, xf, addr});
    else begin
      nb = (op == 2'b10) ? 8 : 1;
      if (err_at >= 0 && err_at < nb) nb = err_at + 1;
      for (int k = 0; k < nb; k++) begin
        if (op == 2'b10)      exp_mem.push_back({2'b10, base + 32'(k * 8)});
        else if (op == 2'b01) exp_mem.push_back({(cfg == 2'b11) ? 2'b01 : 2'b00, base});
        else                  exp_mem.push_back({2'b00, base});
      end
      if (err_at >= 0) exp_cpl.push_back({1'b1, 2'b11, addr});
      else             exp_cpl.push_back({1'b0, 2'b00, addr});
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (!ill && xf == 2'b00) chk(req_ready == 1'b0, "R7 busy", req_ready, 0);
    while (cpl_cnt == n) @(negedge clk);
    @(negedge clk);
    chk(exp_mem.size() == 0, "R6/R4 commands consumed", exp_mem.size(), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_tag = "reset";
    chk(req_ready && !mem_valid && !done_o && !fault_o, "R9", {req_ready, mem_valid, done_o, fault_o}, 4'b1000);

    do_req(2'b00, 32'h0000_1000, 2'b00, 2'b11, -1, 0, "R1 flush aligned");
    do_req(2'b00, 32'h0000_1237, 2'b00, 2'b11, -1, 1, "R2 flush unaligned");
    do_req(2'b00, 32'h0000_127F, 2'b00, 2'b11, -1, 0, "R2 flush all offset bits");
    do_req(2'b01, 32'h0000_2041, 2'b00, 2'b11, -1, 0, "R4 inval true");
    do_req(2'b01, 32'h0000_2041, 2'b00, 2'b01, -1, 0, "R4 inval as flush");
    do_req(2'b01, 32'h0000_2041, 2'b00, 2'b00, -1, 0, "R4 inval cfg00 illegal");
    do_req(2'b01, 32'h0000_2041, 2'b00, 2'b10, -1, 0, "R4 inval cfg10 illegal");
    do_req(2'b11, 32'h0000_5555, 2'b00, 2'b11, -1, 0, "R4 reserved op");
    do_req(2'b01, 32'h0000_2041, 2'b01, 2'b00, -1, 0, "R4 illegal over xlat");
    do_req(2'b10, 32'h0000_3005, 2'b00, 2'b11, -1, 1, "R3 zero stalled");
    do_req(2'b10, 32'hFFFF_FFFF, 2'b00, 2'b11, -1, 0, "R3 zero top block");
    do_req(2'b00, 32'h0000_4009, 2'b01, 2'b11, -1, 0, "R5 page fault");
    do_req(2'b10, 32'h0000_4019, 2'b10, 2'b11, -1, 0, "R5 guest-page fault");
    do_req(2'b01, 32'h0000_4029, 2'b11, 2'b11, -1, 0, "R5 access fault");
    do_req(2'b10, 32'h0000_6033, 2'b00, 2'b11, 3, 1, "R6 zero error mid");
    do_req(2'b00, 32'h0000_7001, 2'b00, 2'b11, 0, 0, "R6 flush error");
    do_req(2'b10, 32'h0000_8000, 2'b00, 2'b11, -1, 0, "R3 zero after abort");

    cur_tag = "end";
    chk(exp_cpl.size() == 0, "R7 completions", exp_cpl.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule